// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit integer datapath. In a single combinational pass it takes a data word, a 3-bit shift-kind code, an 8-bit shift count and the current carry flag. It returns the shifted word and the carry that the shift pushes out. Instruction decoding, register reads and flag writeback belong to the surrounding pipeline. The pipeline routes this block's carry output into the carry flag whenever the instruction asks for flags.

Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. Each kind has its own rule for a count of zero, a count equal to the word width, and a count beyond it. Every value of the 8-bit count is significant. The spare kind codes leave the operand and carry untouched.

Top module: `barrel_shift_core`

## Requirements
- R1: For kind codes 0 to 3 (codes listed in R2 to R7) with a count of zero, the result equals the operand and the carry-out equals the carry input.
- R2: Kind code 0 is logical left; for counts 1 to 31 the result is the operand shifted left with zeros entering at bit 0, and the carry-out is operand bit (32 minus count).
- R3: Kind code 0 with a count of exactly 32 gives a zero result and a carry-out equal to operand bit 0; counts 33 to 255 give a zero result and a zero carry-out.
- R4: Kind code 1 is logical right; for counts 1 to 32 the result is the operand shifted right with zeros entering at bit 31, and the carry-out is operand bit (count minus 1); counts 33 to 255 give zero result and zero carry.
- R5: Kind code 2 is arithmetic right; for counts 1 to 31 the vacated upper bits take operand bit 31, and the carry-out is operand bit (count minus 1).
- R6: Kind code 2 with a count of 32 to 255 sets every result bit and the carry-out to operand bit 31.
- R7: Kind code 3 is rotate right; for a nonzero count it rotates by the count modulo 32 and the carry-out is result bit 31, so a nonzero multiple of 32 returns the operand unchanged with carry-out equal to operand bit 31.
- R8: Kind code 4 rotates through carry: the result is the operand shifted right by one with the carry input in bit 31, the carry-out is operand bit 0, and the count has no effect, including a count of zero.
- R9: Kind codes 5, 6 and 7 return the operand unchanged with the carry-out equal to the carry input, for every count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Data word to be shifted |
| kind_i | input | 3 | Shift kind code (0 left, 1 right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| amt_i | input | 8 | Shift count, 0 to 255 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry shifted out |

## Verification
Two rules claim the same input combination in several places. A zero count with kind 4 falls under both the zero-count pass-through and the rotate-through-carry rule, and R8 must win. A rotate by 32, 64, 96 and so on falls under both the zero-equivalent rotation and the carry-from-bit-31 rule. The bench provokes these collisions by sweeping every kind code against every count from 0 to 255, with operands whose bit 0 and bit 31 differ and with both carry inputs. It judges each result against a model that shifts one bit at a time, so an overlap decided wrongly shows up as a wrong carry or word at that count.

// File: rtl/shift_core_pkg.sv
package shift_core_pkg;
    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shift_kind_e;
endpackage

// File: rtl/shf_left_unit.sv
module shf_left_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] ext;

    // The extra top bit catches the last bit shifted out; it is zero past WIDTH.
    always_comb begin
        ext = {1'b0, opnd_i} << amt_i;
        if (amt_i == '0) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else begin
            result_o = ext[WIDTH-1:0];
            carry_o  = ext[WIDTH];
        end
    end
endmodule

// File: rtl/shf_right_unit.sv
module shf_right_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    parameter bit ARITH = 1'b0
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] ext;

    // The extra bottom bit catches the last bit shifted out.
    generate
        if (ARITH) begin : g_arith
            assign ext = $signed({opnd_i, 1'b0}) >>> amt_i;
        end else begin : g_logic
            assign ext = {opnd_i, 1'b0} >> amt_i;
        end
    endgenerate

    always_comb begin
        if (amt_i == '0) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else begin
            result_o = ext[EXT_W-1:1];
            carry_o  = ext[0];
        end
    end
endmodule

// File: rtl/shf_rotate_unit.sv
module shf_rotate_unit #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    input  logic             thru_carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int ROT_W = $clog2(WIDTH);

    logic [ROT_W-1:0] rot;
    logic [ROT_W:0]   lrot;
    logic [WIDTH-1:0] rotated;

    always_comb begin
        rot     = amt_i[ROT_W-1:0];
        lrot    = (ROT_W+1)'(WIDTH) - {1'b0, rot};
        rotated = (opnd_i >> rot) | (opnd_i << lrot);
        if (thru_carry_i) begin
            result_o = {carry_i, opnd_i[WIDTH-1:1]};
            carry_o  = opnd_i[0];
        end else if (amt_i == '0) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else begin
            result_o = rotated;
            carry_o  = rotated[WIDTH-1];
        end
    end
endmodule

// File: rtl/barrel_shift_core.sv
module barrel_shift_core #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [2:0]       kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    import shift_core_pkg::*;

    shift_kind_e      kind;
    logic [WIDTH-1:0] lsl_res, lsr_res, asr_res, rot_res;
    logic             lsl_c,   lsr_c,   asr_c,   rot_c;

    assign kind = shift_kind_e'(kind_i);

    shf_left_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_lsl (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .result_o(lsl_res), .carry_o(lsl_c));

    shf_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ARITH(1'b0)) u_lsr (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .result_o(lsr_res), .carry_o(lsr_c));

    shf_right_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W), .ARITH(1'b1)) u_asr (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .result_o(asr_res), .carry_o(asr_c));

    shf_rotate_unit #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rot (
        .opnd_i(opnd_i), .amt_i(amt_i), .carry_i(carry_i),
        .thru_carry_i(kind == SK_RRX),
        .result_o(rot_res), .carry_o(rot_c));

    always_comb begin
        unique case (kind)
            SK_LSL:         begin result_o = lsl_res; carry_o = lsl_c; end
            SK_LSR:         begin result_o = lsr_res; carry_o = lsr_c; end
            SK_ASR:         begin result_o = asr_res; carry_o = asr_c; end
            SK_ROR, SK_RRX: begin result_o = rot_res; carry_o = rot_c; end
            default:        begin result_o = opnd_i;  carry_o = carry_i; end
        endcase
    end
endmodule

// File: rtl/barrel_shift_checks.sv
module barrel_shift_checks #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input logic [WIDTH-1:0] opnd_i,
    input logic [2:0]       kind_i,
    input logic [AMT_W-1:0] amt_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o
);
    always_comb begin
        if (kind_i < 3'd4 && amt_i == '0) begin
            p_zero_pass_r1: assert (result_o == opnd_i && carry_o == carry_i);
        end
        if (kind_i == 3'd0 && int'(amt_i) > WIDTH) begin
            p_lsl_clear_r3: assert (result_o == '0 && !carry_o);
        end
        if (kind_i == 3'd1 && int'(amt_i) > WIDTH) begin
            p_lsr_clear_r4: assert (result_o == '0 && !carry_o);
        end
        if (kind_i == 3'd2 && int'(amt_i) >= WIDTH) begin
            p_asr_sat_r6: assert (result_o == {WIDTH{opnd_i[WIDTH-1]}}
                                  && carry_o == opnd_i[WIDTH-1]);
        end
        if (kind_i == 3'd3 && amt_i != '0) begin
            p_rot_carry_r7: assert (carry_o == result_o[WIDTH-1]);
        end
        if (kind_i == 3'd4) begin
            p_thru_carry_r8: assert (result_o[WIDTH-1] == carry_i
                                     && result_o[WIDTH-2:0] == opnd_i[WIDTH-1:1]
                                     && carry_o == opnd_i[0]);
        end
        if (kind_i > 3'd4) begin
            p_spare_pass_r9: assert (result_o == opnd_i && carry_o == carry_i);
        end
    end
endmodule

bind barrel_shift_core barrel_shift_checks #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_checks (
    .opnd_i(opnd_i), .kind_i(kind_i), .amt_i(amt_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o));

// File: tb/tb_barrel_shift_core.sv
module tb_barrel_shift_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       tag;
        logic [2:0]  kind;
        int          amt;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd = '0;
    logic [2:0]  kind = '0;
    logic [7:0]  amt = '0;
    logic        cin = 1'b0;
    logic [31:0] res;
    logic        cout;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit driving_done = 1'b0;
    exp_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_shift_core dut (
        .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .carry_i(cin),
        .result_o(res), .carry_o(cout));

    // Bit-serial reference, written from the requirements.
    function automatic void model(input logic [2:0] k, input int a,
                                  input logic [31:0] v, input logic c_in,
                                  output logic [31:0] r, output logic c,
                                  output string tag);
        r = v;
        c = c_in;
        if (k > 3'd4) begin
            tag = "R9";
        end else if (k == 3'd4) begin
            r = {c_in, v[31:1]}; c = v[0]; tag = "R8";
        end else if (a == 0) begin
            tag = "R1";
        end else if (k == 3'd0) begin
            for (int i = 0; i < a; i++) begin c = r[31]; r = r << 1; end
            tag = (a < 32) ? "R2" : "R3";
        end else if (k == 3'd1) begin
            for (int i = 0; i < a; i++) begin c = r[0]; r = r >> 1; end
            tag = "R4";
        end else if (k == 3'd2) begin
            for (int i = 0; i < a; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            tag = (a < 32) ? "R5" : "R6";
        end else begin
            for (int i = 0; i < a % 32; i++) r = {r[0], r[31:1]};
            c = r[31];
            tag = "R7";
        end
    endfunction

    task automatic drive_one(input logic [2:0] k, input int a,
                             input logic [31:0] v, input logic c_in);
        exp_item_t it;
        @(posedge clk);
        kind = k; amt = 8'(a); opnd = v; cin = c_in;
        model(k, a, v, c_in, it.res, it.cy, it.tag);
        it.kind = k;
        it.amt  = a;
        sb.push_back(it);
    endtask

    // Monitor: outputs settle well before the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_item_t it;
            it = sb.pop_front();
            total++;
            if (res !== it.res || cout !== it.cy) begin
                bad++;
                $display("FAIL %s kind=%0d amt=%0d: got res=%h c=%b expected res=%h c=%b",
                         it.tag, it.kind, it.amt, res, cout, it.res, it.cy);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_3C5A;
        pats[3] = 32'h4000_0003;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Directed boundaries: R1 zero count, R3 exactly 32, R6 saturation, R7 multiple of 32, R8 zero count.
        drive_one(3'd0, 0,  32'h1234_5678, 1'b1);
        drive_one(3'd0, 32, 32'h0000_0001, 1'b0);
        drive_one(3'd2, 40, 32'h8000_0000, 1'b0);
        drive_one(3'd3, 64, 32'h8000_0000, 1'b0);
        drive_one(3'd4, 0,  32'h0000_0003, 1'b1);
        drive_one(3'd6, 9,  32'hDEAD_BEEF, 1'b1);
        // Sweep: every kind code, every count, four operands, both carries.
        for (int k = 0; k < 8; k++) begin
            for (int p = 0; p < 4; p++) begin
                for (int a = 0; a < 256; a++) begin
                    drive_one(3'(k), a, pats[p], logic'((a + p) & 1));
                end
            end
        end
        driving_done = 1'b1;
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule